// File: doc/BRIEF.md
# VGA I/O Port Trap

This block watches the I/O cycles on an internal bus. It raises a system management interrupt request when a cycle addresses one of three legacy VGA port windows whose trap is switched on. The trap handler can then emulate the access in firmware. Each window spans sixteen ports. Each window has its own enable bit, written through a small configuration port. All enables come out of reset cleared, so a machine that has a real graphics adapter never sees a trap.

When an access hits, the block records three things: the 16-bit port number, the access direction and the window that matched. It raises a one-cycle request and sets a sticky pending flag. While the flag is set, later hits are dropped, so the handler always reads the access that caused its entry. The handler clears the flag by writing a one to the status clear port.

Top module: `vga_port_trap`

## Requirements
- R1: An I/O access (io_valid=1, io_is_io=1) whose address lies in an enabled window raises smi_req for exactly one cycle. smi_req is high in the cycle that follows the clock edge at which the access was presented. The windows are 3B0h–3BFh (enable bit 0), 3C0h–3CFh (enable bit 1) and 3D0h–3DFh (enable bit 2).
- R2: A write with cfg_wr=1 loads cfg_wdata into the three enable bits, and trap_en shows their value. Any combination of bits is allowed. An access to a window whose bit is 0 raises no smi_req and leaves pend at 0.
- R3: After reset, trap_en=000, pend=0, smi_req=0, cap_port=0, cap_write=0 and cap_win=000.
- R4: A memory cycle (io_is_io=0) never raises smi_req, even when its address lies inside an enabled window.
- R5: The block decodes 16-bit port numbers. An address with any bit above bit 15 set never matches. Ports 3AFh and 3E0h, which sit just outside the windows, never match.
- R6: At the clock edge where a hit raises smi_req, pend becomes 1 and the capture is loaded. cap_port takes address bits 15:0. cap_write takes io_write (1 = write). cap_win becomes one-hot: bit 0 for 3Bxh, bit 1 for 3Cxh, bit 2 for 3Dxh.
- R7: While pend=1, a further hit raises no smi_req and leaves cap_port, cap_write and cap_win unchanged.
- R8: A status write with sts_wr=1 and sts_wdata=1 clears pend at that clock edge. A status write with sts_wdata=0 has no effect.
- R9: When a status clear and a hit arrive in the same cycle, the hit wins: smi_req pulses, pend stays 1 and the capture takes the new access.
- R10: A cycle with io_valid=0 is ignored, whatever the address and type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Bus cycle present this clock |
| io_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | BUS_AW (32) | Cycle address |
| cfg_wr | input | 1 | Load enable bits |
| cfg_wdata | input | 3 | New enable bits, one per window |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | 1 clears the pending flag |
| trap_en | output | 3 | Current enable bits |
| smi_req | output | 1 | One-cycle interrupt request |
| pend | output | 1 | Sticky pending flag |
| cap_port | output | 16 | Captured port number |
| cap_write | output | 1 | Captured direction |
| cap_win | output | 3 | Captured window, one-hot |

## Verification
A status clear and a new trapped access can land in the same cycle, so the clear and the capture compete for the pending flag. The bench first leaves a trap pending. It then drives a clear together with an access to a different window on a single clock edge. After that edge it expects a fresh request, a pending flag that stays set, and a capture that holds the new port, direction and window. The bench also writes a status value of zero while a trap is pending, to confirm that only a written one releases the flag.

// File: rtl/vga_trap_pkg.sv
package vga_trap_pkg;

    // Width of a decoded I/O port number
    localparam int IO_AW         = 16;
    // Number of trappable windows
    localparam int NUM_WIN       = 3;
    // log2 of the ports per window
    localparam int WIN_PORT_BITS = 4;
    // Width of the window tag compared against the address
    localparam int TAG_W         = IO_AW - WIN_PORT_BITS;
    // Tag of the lowest window (ports 3B0h..3BFh)
    localparam logic [TAG_W-1:0] FIRST_WIN_TAG = TAG_W'(12'h03B);

    typedef logic [NUM_WIN-1:0] win_vec_t;

    typedef struct packed {
        logic [IO_AW-1:0] port;
        logic             write;
        win_vec_t         win;
    } trap_rec_t;

    // Windows lie back to back starting at FIRST_WIN_TAG
    function automatic logic [TAG_W-1:0] win_tag(input int idx);
        return FIRST_WIN_TAG + TAG_W'(idx);
    endfunction

endpackage

// File: rtl/vga_trap_cfg.sv
module vga_trap_cfg
    import vga_trap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_wr,
    input  win_vec_t cfg_wdata,
    output win_vec_t en_q
);

    // Every window starts disabled so an external adapter is never trapped
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (cfg_wr) begin
            en_q <= cfg_wdata;
        end
    end

endmodule

// File: rtl/vga_trap_decode.sv
module vga_trap_decode
    import vga_trap_pkg::*;
#(
    parameter int BUS_AW = 32
) (
    input  logic              io_valid,
    input  logic              io_is_io,
    input  logic [BUS_AW-1:0] io_addr,
    input  win_vec_t          en,
    output win_vec_t          hit
);

    logic upper_zero;
    logic qualify;

    generate
        if (BUS_AW > IO_AW) begin : g_upper
            assign upper_zero = (io_addr[BUS_AW-1:IO_AW] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign qualify = io_valid & io_is_io & upper_zero;

    // One comparator per window; windows are disjoint, so at most one hits
    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        assign hit[gi] = qualify && en[gi] &&
                         (io_addr[IO_AW-1:WIN_PORT_BITS] == win_tag(gi));
    end

endmodule

// File: rtl/vga_trap_capture.sv
module vga_trap_capture
    import vga_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  win_vec_t         hit,
    input  logic [IO_AW-1:0] port,
    input  logic             write,
    input  logic             pend_clr,
    output logic             smi_req,
    output logic             pend_q,
    output trap_rec_t        rec_q
);

    logic take;

    // A hit is accepted when nothing is pending, or when the pending flag
    // is being released in this very cycle (the new hit wins).
    assign take = (|hit) && (!pend_q || pend_clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_req <= 1'b0;
            pend_q  <= 1'b0;
            rec_q   <= '0;
        end else begin
            smi_req <= take;
            if (take) begin
                pend_q      <= 1'b1;
                rec_q.port  <= port;
                rec_q.write <= write;
                rec_q.win   <= hit;
            end else if (pend_clr) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vga_port_trap.sv
module vga_port_trap
    import vga_trap_pkg::*;
#(
    parameter int BUS_AW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_valid,
    input  logic               io_is_io,
    input  logic               io_write,
    input  logic [BUS_AW-1:0]  io_addr,
    input  logic               cfg_wr,
    input  logic [NUM_WIN-1:0] cfg_wdata,
    input  logic               sts_wr,
    input  logic               sts_wdata,
    output logic [NUM_WIN-1:0] trap_en,
    output logic               smi_req,
    output logic               pend,
    output logic [IO_AW-1:0]   cap_port,
    output logic               cap_write,
    output logic [NUM_WIN-1:0] cap_win
);

    win_vec_t  en_q;
    win_vec_t  hit;
    trap_rec_t rec;
    logic      pend_clr;

    assign pend_clr = sts_wr & sts_wdata;

    vga_trap_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .en_q     (en_q)
    );

    vga_trap_decode #(.BUS_AW(BUS_AW)) u_decode (
        .io_valid(io_valid),
        .io_is_io(io_is_io),
        .io_addr (io_addr),
        .en      (en_q),
        .hit     (hit)
    );

    vga_trap_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .port    (io_addr[IO_AW-1:0]),
        .write   (io_write),
        .pend_clr(pend_clr),
        .smi_req (smi_req),
        .pend_q  (pend),
        .rec_q   (rec)
    );

    assign trap_en   = en_q;
    assign cap_port  = rec.port;
    assign cap_write = rec.write;
    assign cap_win   = rec.win;

endmodule

// File: rtl/vga_port_trap_chk.sv
module vga_port_trap_chk
    import vga_trap_pkg::*;
#(
    parameter int BUS_AW = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               io_valid,
    input logic               io_is_io,
    input logic               sts_wr,
    input logic               sts_wdata,
    input logic [NUM_WIN-1:0] trap_en,
    input logic               smi_req,
    input logic               pend,
    input logic [IO_AW-1:0]   cap_port,
    input logic               cap_write,
    input logic [NUM_WIN-1:0] cap_win
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (trap_en == '0) && !pend && !smi_req); // R3

    AST_SMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (smi_req && !(sts_wr && sts_wdata)) |=> !smi_req); // R1

    AST_SMI_NEEDS_IO: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(io_valid && io_is_io)); // R4

    AST_SMI_ENABLED_WIN: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> ((cap_win & $past(trap_en)) != '0)); // R2

    AST_SMI_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> pend); // R6

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cap_win)); // R6

    AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pend |-> (cap_port[IO_AW-1:WIN_PORT_BITS] >= win_tag(0)) &&
                 (cap_port[IO_AW-1:WIN_PORT_BITS] <= win_tag(NUM_WIN-1))); // R5

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend && !(sts_wr && sts_wdata)) |=>
            $stable(cap_port) && $stable(cap_win) && $stable(cap_write) && !smi_req); // R7

    AST_CLEAR_OR_RETRAP: assert property (@(posedge clk) disable iff (rst)
        (pend && sts_wr && sts_wdata) |=> (!pend || smi_req)); // R8

endmodule

bind vga_port_trap vga_port_trap_chk #(.BUS_AW(BUS_AW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .io_valid (io_valid),
    .io_is_io (io_is_io),
    .sts_wr   (sts_wr),
    .sts_wdata(sts_wdata),
    .trap_en  (trap_en),
    .smi_req  (smi_req),
    .pend     (pend),
    .cap_port (cap_port),
    .cap_write(cap_write),
    .cap_win  (cap_win)
);

// File: tb/test_vga_port_trap.sv
`timescale 1ns/1ps
module test_vga_port_trap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0;
    logic        io_is_io = 1'b0;
    logic        io_write = 1'b0;
    logic [31:0] io_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic        sts_wr = 1'b0;
    logic        sts_wdata = 1'b0;
    logic [2:0]  trap_en;
    logic        smi_req;
    logic        pend;
    logic [15:0] cap_port;
    logic        cap_write;
    logic [2:0]  cap_win;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vga_port_trap #(.BUS_AW(32)) i_vga_port_trap (
        .clk(clk), .rst(rst),
        .io_valid(io_valid), .io_is_io(io_is_io), .io_write(io_write), .io_addr(io_addr),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .trap_en(trap_en), .smi_req(smi_req), .pend(pend),
        .cap_port(cap_port), .cap_write(cap_write), .cap_win(cap_win)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one bus cycle for one clock; returns 1 ns after the edge
    task automatic io_access(input logic [31:0] a, input logic wr,
                             input logic isio, input logic vld = 1'b1);
        @(negedge clk);
        io_valid = vld; io_is_io = isio; io_write = wr; io_addr = a;
        @(posedge clk); #1;
        io_valid = 1'b0; io_is_io = 1'b0; io_write = 1'b0; io_addr = '0;
    endtask

    task automatic set_en(input logic [2:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic status_write(input logic d);
        @(negedge clk);
        sts_wr = 1'b1; sts_wdata = d;
        @(posedge clk); #1;
        sts_wr = 1'b0; sts_wdata = 1'b0;
    endtask

    task automatic t_reset();
        check("R3", "trap_en", 32'(trap_en), 32'h0);
        check("R3", "pend", 32'(pend), 32'h0);
        check("R3", "smi_req", 32'(smi_req), 32'h0);
        check("R3", "cap_port", 32'(cap_port), 32'h0);
        check("R3", "cap_write", 32'(cap_write), 32'h0);
        check("R3", "cap_win", 32'(cap_win), 32'h0);
    endtask

    task automatic t_disabled();
        io_access(32'h3B4, 1'b1, 1'b1);
        check("R2", "smi off 3B4", 32'(smi_req), 32'h0);
        io_access(32'h3C0, 1'b0, 1'b1);
        check("R2", "smi off 3C0", 32'(smi_req), 32'h0);
        io_access(32'h3DF, 1'b1, 1'b1);
        check("R2", "smi off 3DF", 32'(smi_req), 32'h0);
        check("R2", "pend off", 32'(pend), 32'h0);
    endtask

    task automatic t_each_window();
        for (int i = 0; i < 3; i++) begin
            logic [31:0] a;
            a = 32'h3B0 + 32'(i * 16) + 32'(i * 5);
            set_en(3'(1 << i));
            check("R2", "trap_en readback", 32'(trap_en), 32'(1 << i));
            // the other two windows stay silent
            for (int j = 0; j < 3; j++) begin
                if (j != i) begin
                    io_access(32'h3B8 + 32'(j * 16), 1'b0, 1'b1);
                    check("R2", "other window no smi", 32'(smi_req), 32'h0);
                end
            end
            io_access(a, i[0], 1'b1);
            check("R1", "smi on hit", 32'(smi_req), 32'h1);
            check("R6", "pend on hit", 32'(pend), 32'h1);
            check("R6", "cap_port", 32'(cap_port), a);
            check("R6", "cap_write", 32'(cap_write), 32'(i[0]));
            check("R6", "cap_win", 32'(cap_win), 32'(1 << i));
            @(posedge clk); #1;
            check("R1", "smi one cycle", 32'(smi_req), 32'h0);
            status_write(1'b1);
            check("R8", "pend cleared", 32'(pend), 32'h0);
        end
    endtask

    task automatic t_edges();
        set_en(3'b111);
        io_access(32'h3AF, 1'b0, 1'b1);
        check("R5", "3AF no smi", 32'(smi_req), 32'h0);
        io_access(32'h3E0, 1'b0, 1'b1);
        check("R5", "3E0 no smi", 32'(smi_req), 32'h0);
        io_access(32'h0001_03B0, 1'b0, 1'b1);
        check("R5", "upper bit no smi", 32'(smi_req), 32'h0);
        io_access(32'h8000_03C4, 1'b1, 1'b1);
        check("R5", "bit31 no smi", 32'(smi_req), 32'h0);
        check("R5", "pend still 0", 32'(pend), 32'h0);
        io_access(32'h3DF, 1'b0, 1'b1);
        check("R5", "3DF hit", 32'(smi_req), 32'h1);
        check("R5", "3DF win", 32'(cap_win), 32'h4);
        status_write(1'b1);
        io_access(32'h3B0, 1'b1, 1'b1);
        check("R5", "3B0 hit", 32'(smi_req), 32'h1);
        check("R5", "3B0 port", 32'(cap_port), 32'h3B0);
        status_write(1'b1);
    endtask

    task automatic t_ignored();
        io_access(32'h3C5, 1'b1, 1'b0);
        check("R4", "memory cycle no smi", 32'(smi_req), 32'h0);
        check("R4", "memory cycle no pend", 32'(pend), 32'h0);
        io_access(32'h3C5, 1'b1, 1'b1, 1'b0);
        check("R10", "invalid no smi", 32'(smi_req), 32'h0);
        check("R10", "invalid no pend", 32'(pend), 32'h0);
    endtask

    task automatic t_pending();
        io_access(32'h3C4, 1'b0, 1'b1);
        check("R6", "first hit smi", 32'(smi_req), 32'h1);
        io_access(32'h3D8, 1'b1, 1'b1);
        check("R7", "second hit no smi", 32'(smi_req), 32'h0);
        check("R7", "port kept", 32'(cap_port), 32'h3C4);
        check("R7", "write kept", 32'(cap_write), 32'h0);
        check("R7", "win kept", 32'(cap_win), 32'h2);
        status_write(1'b0);
        check("R8", "zero write keeps pend", 32'(pend), 32'h1);
        status_write(1'b1);
        check("R8", "one write clears pend", 32'(pend), 32'h0);
        check("R8", "no smi on clear", 32'(smi_req), 32'h0);
    endtask

    task automatic t_collide();
        io_access(32'h3C4, 1'b0, 1'b1);
        check("R9", "setup pend", 32'(pend), 32'h1);
        @(negedge clk);
        sts_wr = 1'b1; sts_wdata = 1'b1;
        io_valid = 1'b1; io_is_io = 1'b1; io_write = 1'b1; io_addr = 32'h3BA;
        @(posedge clk); #1;
        sts_wr = 1'b0; sts_wdata = 1'b0;
        io_valid = 1'b0; io_is_io = 1'b0; io_write = 1'b0; io_addr = '0;
        check("R9", "smi on collide", 32'(smi_req), 32'h1);
        check("R9", "pend kept", 32'(pend), 32'h1);
        check("R9", "new port", 32'(cap_port), 32'h3BA);
        check("R9", "new write", 32'(cap_write), 32'h1);
        check("R9", "new win", 32'(cap_win), 32'h1);
        status_write(1'b1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_disabled();
        t_each_window();
        t_edges();
        t_ignored();
        t_pending();
        t_collide();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule